// File: doc/BRIEF.md
# Three-Wire Control Register Receiver

This block is the slave side of a three-wire serial control port. A host drives a control clock, a mode line and a data line; the block oversamples all three in the system clock domain, assembles bytes, and turns them into writes to a small set of audio configuration registers. The registers drive the system-clock ratio select, the serial input format select, a 6-bit volume attenuation code, a de-emphasis select and a mute bit.

A transfer has two phases set by the mode line. With the mode line low the host sends one address byte that names the device and picks one of two register banks. With the mode line high it sends any number of data bytes; each carries a 2-bit sub-register code in its upper bits and a 6-bit value below it. Data bytes reach a register only while the port is selected and a valid bank is chosen.

Top module: `ctl_serial_rx`

## Requirements
- R1: A byte is eight bits sent least significant bit first. No register changes until all eight bits of a byte have arrived; bits of an unfinished byte are dropped when the mode line changes.
- R2: Mode line low marks address mode and high marks data mode. Each change of the mode line restarts the bit count, so the next byte starts at bit 0.
- R3: In an address byte, bits 7:2 are the device address. Value 6'b000101 selects the port; any other value deselects it, and data bytes sent while deselected change no output.
- R4: Address byte bits 1:0 choose the bank: 2'b00 the audio bank, 2'b10 the status bank. With 2'b01 or 2'b11 all data bytes are ignored.
- R5: The selection and bank last over any number of data bytes until the next address byte.
- R6: In the status bank, a data byte whose bits 7:6 are 2'b00 loads clock select from bits 5:4 (00 512fs, 01 384fs, 10 256fs) and format from bits 3:1 (000 I2S, 001/010/011 LSB-justified 16/18/20 bit, 100 MSB-justified). Other codes in this bank are ignored.
- R7: In the audio bank, code 2'b00 loads volume from bits 5:0 (0 = 0 dB, one step per dB of attenuation). Code 2'b10 loads de-emphasis from bits 2:1 (00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz) and mute from bit 0. Codes 2'b01 and 2'b11 are ignored.
- R8: After reset: clock select 2'b10, format 3'b000, volume 0, de-emphasis 2'b00, mute 0, port deselected.
- R9: A data bit is taken on the rising edge of the control clock; the data line may change while the clock is high or on its falling edge without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Control port bit clock |
| ser_mode_i | input | 1 | Control port mode line (0 address, 1 data) |
| ser_dat_i | input | 1 | Control port data line |
| clk_sel_o | output | 2 | System clock ratio select |
| fmt_sel_o | output | 3 | Serial input format select |
| vol_o | output | 6 | Volume attenuation code |
| deemph_o | output | 2 | De-emphasis select |
| mute_o | output | 1 | Mute enable |

## Verification
On every cycle the assertions check that the configuration outputs hold still unless a finished byte was just delivered, that address bytes and bytes arriving while deselected never alter them, that a byte is delivered only after the eighth counted bit, and that a mode-line change clears the bit count. The actual field decoding, the bank and address matching, the persistence of selection across many data bytes, the dropping of a partial byte and the insensitivity to data changes while the clock is high can only be shown by the bench, which compares every output after each byte against its own register model under directed and random byte streams.

// File: rtl/ctl_rx_pkg.sv
package ctl_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    BANK_AUDIO  = 2'b00,
    BANK_SPARE1 = 2'b01,
    BANK_STATUS = 2'b10,
    BANK_SPARE3 = 2'b11
  } bank_e;

  localparam logic [1:0] SUB_LOAD0 = 2'b00;
  localparam logic [1:0] SUB_LOAD2 = 2'b10;

  localparam logic [1:0] RST_CLK_SEL = 2'b10;
  localparam logic [2:0] RST_FMT     = 3'b000;
  localparam logic [5:0] RST_VOL     = 6'd0;
  localparam logic [1:0] RST_DEEMPH  = 2'b00;
endpackage

// File: rtl/ctl_rx_sync.sv
module ctl_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ctl_rx_shift.sv
module ctl_rx_shift
  import ctl_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mode_s,
  input  logic              dat_s,
  output logic              byte_vld_o,
  output logic              byte_mode_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_q, mode_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              vld_q, vld_d;
  logic              bmode_q, bmode_d;
  logic [BYTE_W-1:0] bdata_q, bdata_d;
  logic              rise, mode_chg;
  logic [BYTE_W-1:0] sh_next;

  assign rise     = sclk_s & ~sclk_q;
  assign mode_chg = mode_s ^ mode_q;
  assign sh_next  = {dat_s, sh_q[BYTE_W-1:1]};

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    vld_d   = 1'b0;
    bmode_d = bmode_q;
    bdata_d = bdata_q;
    if (mode_chg) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (rise) begin
      sh_d = sh_next;
      if (cnt_q == LAST_BIT) begin
        cnt_d   = '0;
        vld_d   = 1'b1;
        bmode_d = mode_s;
        bdata_d = sh_next;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      mode_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      vld_q   <= 1'b0;
      bmode_q <= 1'b0;
      bdata_q <= '0;
    end else begin
      sclk_q  <= sclk_s;
      mode_q  <= mode_s;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      vld_q   <= vld_d;
      bmode_q <= bmode_d;
      bdata_q <= bdata_d;
    end
  end

  assign byte_vld_o  = vld_q;
  assign byte_mode_o = bmode_q;
  assign byte_data_o = bdata_q;
  assign bit_cnt_o   = cnt_q;
endmodule

// File: rtl/ctl_rx_regs.sv
module ctl_rx_regs
  import ctl_rx_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR = 6'b000101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic              byte_mode_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  output logic              sel_o,
  output logic [1:0]        clk_sel_o,
  output logic [2:0]        fmt_sel_o,
  output logic [5:0]        vol_o,
  output logic [1:0]        deemph_o,
  output logic              mute_o
);
  logic       sel_q, sel_d;
  bank_e      bank_q, bank_d;
  logic [1:0] clk_q, clk_d;
  logic [2:0] fmt_q, fmt_d;
  logic [5:0] vol_q, vol_d;
  logic [1:0] de_q, de_d;
  logic       mute_q, mute_d;
  logic       wr_en;
  logic [1:0] sub;

  assign sub   = byte_data_i[7:6];
  assign wr_en = byte_vld_i & byte_mode_i & sel_q;

  always_comb begin
    sel_d  = sel_q;
    bank_d = bank_q;
    clk_d  = clk_q;
    fmt_d  = fmt_q;
    vol_d  = vol_q;
    de_d   = de_q;
    mute_d = mute_q;
    if (byte_vld_i && !byte_mode_i) begin
      sel_d  = (byte_data_i[7:2] == DEV_ADDR);
      bank_d = bank_e'(byte_data_i[1:0]);
    end
    if (wr_en) begin
      unique case (bank_q)
        BANK_AUDIO: begin
          if (sub == SUB_LOAD0) begin
            vol_d = byte_data_i[5:0];
          end else if (sub == SUB_LOAD2) begin
            de_d   = byte_data_i[2:1];
            mute_d = byte_data_i[0];
          end
        end
        BANK_STATUS: begin
          if (sub == SUB_LOAD0) begin
            clk_d = byte_data_i[5:4];
            fmt_d = byte_data_i[3:1];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      bank_q <= BANK_AUDIO;
      clk_q  <= RST_CLK_SEL;
      fmt_q  <= RST_FMT;
      vol_q  <= RST_VOL;
      de_q   <= RST_DEEMPH;
      mute_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      bank_q <= bank_d;
      clk_q  <= clk_d;
      fmt_q  <= fmt_d;
      vol_q  <= vol_d;
      de_q   <= de_d;
      mute_q <= mute_d;
    end
  end

  assign sel_o     = sel_q;
  assign clk_sel_o = clk_q;
  assign fmt_sel_o = fmt_q;
  assign vol_o     = vol_q;
  assign deemph_o  = de_q;
  assign mute_o    = mute_q;
endmodule

// File: rtl/ctl_serial_rx.sv
module ctl_serial_rx
  import ctl_rx_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ADDR    = 6'b000101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk_i,
  input  logic       ser_mode_i,
  input  logic       ser_dat_i,
  output logic [1:0] clk_sel_o,
  output logic [2:0] fmt_sel_o,
  output logic [5:0] vol_o,
  output logic [1:0] deemph_o,
  output logic       mute_o
);
  logic [2:0]        pins_s;
  logic              byte_vld, byte_mode, port_sel;
  logic [BYTE_W-1:0] byte_data;
  logic [CNT_W-1:0]  bit_cnt;

  ctl_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_clk_i, ser_mode_i, ser_dat_i}),
    .q_o   (pins_s)
  );

  ctl_rx_shift u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_s      (pins_s[2]),
    .mode_s      (pins_s[1]),
    .dat_s       (pins_s[0]),
    .byte_vld_o  (byte_vld),
    .byte_mode_o (byte_mode),
    .byte_data_o (byte_data),
    .bit_cnt_o   (bit_cnt)
  );

  ctl_rx_regs #(.DEV_ADDR(DEV_ADDR)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld_i  (byte_vld),
    .byte_mode_i (byte_mode),
    .byte_data_i (byte_data),
    .sel_o       (port_sel),
    .clk_sel_o   (clk_sel_o),
    .fmt_sel_o   (fmt_sel_o),
    .vol_o       (vol_o),
    .deemph_o    (deemph_o),
    .mute_o      (mute_o)
  );
endmodule

// File: rtl/ctl_serial_rx_chk.sv
module ctl_serial_rx_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_s,
  input logic             byte_vld,
  input logic             byte_mode,
  input logic             port_sel,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [13:0]      cfg
);
  AST_HOLD_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(cfg));  // R1

  AST_BYTE_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> ($past(bit_cnt) == CNT_W'(2**CNT_W - 1)));  // R1

  AST_MODE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s != $past(mode_s)) |=> (bit_cnt == '0));  // R2

  AST_DESELECTED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_mode && !port_sel) |=> $stable(cfg));  // R3

  AST_ADDRESS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_mode) |=> $stable(cfg));  // R3

  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);  // R1
endmodule

bind ctl_serial_rx ctl_serial_rx_chk #(.CNT_W(3)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_s    (pins_s[1]),
  .byte_vld  (byte_vld),
  .byte_mode (byte_mode),
  .port_sel  (port_sel),
  .bit_cnt   (bit_cnt),
  .cfg       ({clk_sel_o, fmt_sel_o, vol_o, deemph_o, mute_o})
);

// File: tb/test_ctl_serial_rx.sv
module test_ctl_serial_rx;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, sclk, smode, sdat;
  logic [1:0] clk_sel;
  logic [2:0] fmt_sel;
  logic [5:0] vol;
  logic [1:0] deemph;
  logic       mute;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic       e_sel;
  logic [1:0] e_bank, e_clk, e_de;
  logic [2:0] e_fmt;
  logic [5:0] e_vol;
  logic       e_mute;

  ctl_serial_rx i_ctl_serial_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk_i  (sclk),
    .ser_mode_i (smode),
    .ser_dat_i  (sdat),
    .clk_sel_o  (clk_sel),
    .fmt_sel_o  (fmt_sel),
    .vol_o      (vol),
    .deemph_o   (deemph),
    .mute_o     (mute)
  );

  function automatic logic [13:0] exp_cfg();
    return {e_clk, e_fmt, e_vol, e_de, e_mute};
  endfunction

  task automatic model(input logic m, input logic [7:0] b);
    if (!m) begin
      e_sel  = (b[7:2] == 6'b000101);
      e_bank = b[1:0];
    end else if (e_sel) begin
      if (e_bank == 2'b00) begin
        if (b[7:6] == 2'b00) e_vol = b[5:0];
        else if (b[7:6] == 2'b10) begin e_de = b[2:1]; e_mute = b[0]; end
      end else if (e_bank == 2'b10) begin
        if (b[7:6] == 2'b00) begin e_clk = b[5:4]; e_fmt = b[3:1]; end
      end
    end
  endtask

  task automatic check(input string req);
    logic [13:0] act;
    act = {clk_sel, fmt_sel, vol, deemph, mute};
    n_tests++;
    if (act !== exp_cfg()) begin
      n_fail++;
      $display("FAIL %s: outputs actual %h expected %h", req, act, exp_cfg());
    end
  endtask

  // bit taken on the rising edge; data is flipped while clock is high (R9)
  task automatic send_bits(input logic m, input logic [7:0] b, input int n);
    smode = m;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdat = b[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sdat = ~b[i];
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic m, input logic [7:0] b, input string req);
    send_bits(m, b, 8);
    model(m, b);
    check(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic       m;
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; sclk = 1'b0; smode = 1'b0; sdat = 1'b0;
    e_sel = 1'b0; e_bank = 2'b00; e_clk = 2'b10; e_fmt = 3'b000;
    e_vol = 6'd0; e_de = 2'b00; e_mute = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 reset values");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 after reset release");

    xfer(1'b1, 8'h2A, "R3 data while deselected");
    xfer(1'b0, 8'h14, "R3 address match audio bank");
    xfer(1'b1, 8'h2A, "R7 volume load");
    xfer(1'b1, 8'h87, "R5 second data byte de-emphasis and mute");
    xfer(1'b1, 8'h3F, "R5 third data byte volume");
    xfer(1'b1, 8'h7F, "R7 code 01 ignored");
    xfer(1'b1, 8'hC0, "R7 code 11 ignored");
    xfer(1'b1, 8'h84, "R7 de-emphasis 44.1k mute off");
    xfer(1'b0, 8'h16, "R4 status bank select");
    xfer(1'b1, 8'h18, "R6 clock 384fs MSB-justified");
    xfer(1'b1, 8'h86, "R6 code 10 ignored in status bank");
    xfer(1'b1, 8'h06, "R6 clock 512fs LSB 20 bit");
    xfer(1'b0, 8'h15, "R4 bank 01");
    xfer(1'b1, 8'h05, "R4 bank 01 data ignored");
    xfer(1'b0, 8'h17, "R4 bank 11");
    xfer(1'b1, 8'h00, "R4 bank 11 data ignored");
    xfer(1'b0, 8'h24, "R3 wrong address");
    xfer(1'b1, 8'h11, "R3 wrong address data ignored");
    xfer(1'b0, 8'h14, "R3 reselect audio bank");

    send_bits(1'b1, 8'h01, 5);
    check("R1 partial byte leaves outputs");
    xfer(1'b0, 8'h14, "R2 address after discarded partial");
    xfer(1'b1, 8'h09, "R2 count restarted on mode change");
    xfer(1'b1, 8'h1B, "R9 rising-edge capture");

    for (int k = 0; k < 60; k++) begin
      m = $urandom_range(0, 2) != 0;
      b = 8'($urandom);
      if (!m && ($urandom_range(0, 9) < 7)) b[7:2] = 6'b000101;
      if (m) xfer(m, b, "R6 R7 random data byte");
      else   xfer(m, b, "R3 R4 random address byte");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule